// File: doc/BRIEF.md
# Modular Exponentiation Engine (Square-and-Multiply)

This block raises a base to a power modulo a small odd or even modulus: y = x^e mod n. Operands are `W` bits wide, 16 by default. A one-cycle `start` pulse captures x, e and n. The block then walks the exponent from its top bit down to bit 0. For each bit it squares the running value, and when the bit is set it multiplies by x. Every multiplication is reduced modulo n as it is formed, so no intermediate value ever reaches n.

The product unit is an interleaved shift-add modular multiplier. It consumes one multiplier bit per clock and uses conditional subtractions of n to keep its partial sum in the range 0..n-1.

A `ct_mode` input is sampled with `start`. When it is high, all `W` exponent bits are processed, and the multiply by x runs for every bit whether the bit is set or not. A product that is not wanted is thrown away. The run length and the operation order therefore carry no exponent information. When `ct_mode` is low, leading zero bits of e are skipped and the multiply runs only for set bits.

Top module: `modexp_sqm`

## Requirements
- R1: When `done` pulses, `y` equals x^e mod n for any operands with x < n and n > 1.
- R2: An exponent of 0 yields `y` = 1 in both modes.
- R3: A `start` pulse that arrives while `busy` is high is ignored: the running job completes with its original operands.
- R4: The running value and the multiplier's partial sum stay below n, and the final `y` is below n.
- R5: With `ct_mode` high, the number of cycles from `start` to `done` is the same for every exponent. Every squaring is followed by a multiply, and the result equals the result in normal mode.
- R6: With `ct_mode` low, the multiply by x runs only for set exponent bits, and leading zero bits are skipped. As a result, e = 1 finishes in fewer cycles than e = 2^(W-1).
- R7: `busy` is high from the cycle after an accepted `start` until the result is ready. `done` is a one-cycle pulse, and `busy` is already low in that cycle. `y` holds its value until the next job completes.
- R8: For n = 143, e = 7 and x = 115, the result is 80 in both modes.
- R9: After reset, `busy`, `done` and `y` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a job; sampled only while idle |
| ct_mode | input | 1 | 1 = constant-time operation for this job |
| x_in | input | W | Base; must be below n_in |
| e_in | input | W | Exponent |
| n_in | input | W | Modulus; must exceed 1 |
| y_out | output | W | Result, held between jobs |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle result-ready pulse |

## Verification
The bench builds the block with its default width of 16 bits. This width covers moduli up to 65535. At those sizes, doubling the partial sum needs a 17th bit, so the carry path of the conditional subtraction is exercised. It also makes the cycle-count comparisons meaningful: in normal mode, a single-bit exponent at the bottom and one at the top differ by fifteen squarings. In constant-time mode, all-zero, single-bit and all-ones exponents must take an identical number of cycles.

// File: rtl/modexp_pkg.sv
// Shared types for the modular exponentiation engine.
package modexp_pkg;

    // Controller sequencing states.
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SKIP    = 3'd1,
        ST_SQ_GO   = 3'd2,
        ST_SQ_WAIT = 3'd3,
        ST_MU_GO   = 3'd4,
        ST_MU_WAIT = 3'd5,
        ST_NEXT    = 3'd6
    } sqm_state_t;

endpackage

// File: rtl/modmul_serial.sv
// Interleaved shift-add modular multiplier: p = a*b mod n.
// Processes one bit of b per cycle, MSB first. Each step doubles the
// partial sum and optionally adds a, and each of those two moves is
// followed by one conditional subtraction of n.
// Assumes a < n and n > 1 on go; the result is valid when done pulses,
// W+1 cycles after go.
module modmul_serial #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] n,
    output logic [W-1:0] p,
    output logic         busy,
    output logic         done
);
    localparam int CW = $clog2(W + 1);
    localparam int XW = W + 2;

    logic [W-1:0]  a_q, b_q, n_q, sum_q;
    logic [CW-1:0] cnt_q;
    logic [XW-1:0] dbl, dbl_r, add, add_r;

    // One reduction step: double, reduce, conditionally add a, reduce.
    always_comb begin
        dbl   = {1'b0, sum_q, 1'b0};
        dbl_r = (dbl >= XW'(n_q)) ? dbl - XW'(n_q) : dbl;
        add   = b_q[W-1] ? dbl_r + XW'(a_q) : dbl_r;
        add_r = (add >= XW'(n_q)) ? add - XW'(n_q) : add;
    end

    // Operand capture, bit iteration and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            n_q   <= '0;
            sum_q <= '0;
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (go) begin
                    a_q   <= a;
                    b_q   <= b;
                    n_q   <= n;
                    sum_q <= '0;
                    cnt_q <= CW'(W);
                    busy  <= 1'b1;
                end
            end else begin
                sum_q <= add_r[W-1:0];
                b_q   <= {b_q[W-2:0], 1'b0};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign p = sum_q;

    AST_PARTIAL_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (sum_q < n_q)); // R4
    AST_MUL_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R7

endmodule

// File: rtl/sqm_ctrl.sv
// Square-and-multiply sequencer. It scans the exponent MSB first, issues
// a squaring for every scanned bit and a multiply by x after it when the
// bit is set (or always, in constant-time mode, discarding the unused
// product). Assumes x < n and n > 1; start is ignored while a job runs.
module sqm_ctrl
    import modexp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ct_mode,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] e_in,
    input  logic [W-1:0] n_in,
    output logic         mul_go,
    output logic [W-1:0] mul_a,
    output logic [W-1:0] mul_b,
    output logic [W-1:0] mul_n,
    input  logic [W-1:0] mul_p,
    input  logic         mul_done,
    output logic [W-1:0] y,
    output logic         busy,
    output logic         done
);
    localparam int CW = $clog2(W + 1);

    sqm_state_t    st_q;
    logic [W-1:0]  x_q, e_q, n_q, acc_q;
    logic [CW-1:0] bits_q;
    logic          ct_q;
    logic          cur_bit;

    assign cur_bit = e_q[W-1];
    assign busy    = (st_q != ST_IDLE);
    assign mul_go  = (st_q == ST_SQ_GO) || (st_q == ST_MU_GO);
    assign mul_a   = acc_q;
    assign mul_b   = (st_q == ST_MU_GO) ? x_q : acc_q;
    assign mul_n   = n_q;

    // Job sequencing, running value update and result latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            x_q    <= '0;
            e_q    <= '0;
            n_q    <= '0;
            acc_q  <= '0;
            bits_q <= '0;
            ct_q   <= 1'b0;
            y      <= '0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (start) begin
                    x_q    <= x_in;
                    e_q    <= e_in;
                    n_q    <= n_in;
                    ct_q   <= ct_mode;
                    acc_q  <= W'(1);
                    bits_q <= CW'(W);
                    st_q   <= ct_mode ? ST_SQ_GO : ST_SKIP;
                end
                ST_SKIP: begin
                    if (bits_q == '0) begin
                        y    <= acc_q;
                        done <= 1'b1;
                        st_q <= ST_IDLE;
                    end else if (cur_bit) begin
                        st_q <= ST_SQ_GO;
                    end else begin
                        e_q    <= {e_q[W-2:0], 1'b0};
                        bits_q <= bits_q - 1'b1;
                    end
                end
                ST_SQ_GO:   st_q <= ST_SQ_WAIT;
                ST_SQ_WAIT: if (mul_done) begin
                    acc_q <= mul_p;
                    st_q  <= (cur_bit || ct_q) ? ST_MU_GO : ST_NEXT;
                end
                ST_MU_GO:   st_q <= ST_MU_WAIT;
                ST_MU_WAIT: if (mul_done) begin
                    if (cur_bit) acc_q <= mul_p;
                    st_q <= ST_NEXT;
                end
                ST_NEXT: begin
                    e_q    <= {e_q[W-2:0], 1'b0};
                    bits_q <= bits_q - 1'b1;
                    if (bits_q == CW'(1)) begin
                        y    <= acc_q;
                        done <= 1'b1;
                        st_q <= ST_IDLE;
                    end else begin
                        st_q <= ST_SQ_GO;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    AST_ACC_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && st_q != ST_SKIP) |-> (acc_q < n_q)); // R4
    AST_CT_ALWAYS_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_SQ_WAIT && mul_done && ct_q) |=> (st_q == ST_MU_GO)); // R5
    AST_MUL_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MU_GO) |-> (ct_q || cur_bit)); // R6
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R7
    AST_Y_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(y) |-> done); // R7
    AST_Y_BELOW_N: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (y < n_q)); // R4
    AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(x_q) && $stable(n_q) && $stable(ct_q))); // R3

endmodule

// File: rtl/modexp_sqm.sv
// Top of the modular exponentiation engine: the sequencer drives one
// serial modular multiplier shared by squarings and multiplies.
// Assumes x_in < n_in and n_in > 1 when start is accepted.
module modexp_sqm #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         ct_mode,
    input  logic [W-1:0] x_in,
    input  logic [W-1:0] e_in,
    input  logic [W-1:0] n_in,
    output logic [W-1:0] y_out,
    output logic         busy,
    output logic         done
);
    logic         mul_go, mul_busy, mul_done;
    logic [W-1:0] mul_a, mul_b, mul_n, mul_p;

    sqm_ctrl #(.W(W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .ct_mode  (ct_mode),
        .x_in     (x_in),
        .e_in     (e_in),
        .n_in     (n_in),
        .mul_go   (mul_go),
        .mul_a    (mul_a),
        .mul_b    (mul_b),
        .mul_n    (mul_n),
        .mul_p    (mul_p),
        .mul_done (mul_done),
        .y        (y_out),
        .busy     (busy),
        .done     (done)
    );

    modmul_serial #(.W(W)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (mul_go),
        .a     (mul_a),
        .b     (mul_b),
        .n     (mul_n),
        .p     (mul_p),
        .busy  (mul_busy),
        .done  (mul_done)
    );

    AST_GO_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        mul_go |-> !mul_busy); // R1

endmodule

// File: tb/sim_modexp_sqm.sv
module sim_modexp_sqm;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         ct_mode = 1'b0;
    logic [W-1:0] x_in = '0, e_in = '0, n_in = '0;
    logic [W-1:0] y_out;
    logic         busy, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    modexp_sqm #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .ct_mode(ct_mode),
        .x_in(x_in), .e_in(e_in), .n_in(n_in),
        .y_out(y_out), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Right-to-left reference, independent of the design's scan order.
    function automatic longint ref_pow(input longint x, input longint e, input longint n);
        longint r = 1;
        longint b = x % n;
        for (int i = 0; i < W; i++) begin
            if (e[i]) r = (r * b) % n;
            b = (b * b) % n;
        end
        return r % n;
    endfunction

    // Launch one job, wait for done, check handshake (R7) and range (R4).
    task automatic run(input logic [W-1:0] x, input logic [W-1:0] e,
                       input logic [W-1:0] n, input bit ct,
                       output logic [W-1:0] y, output int cyc);
        @(negedge clk);
        x_in = x; e_in = e; n_in = n; ct_mode = ct; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        chk(busy == 1'b1, "R7 busy after start", longint'(busy), 1);
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, "R7 done seen", longint'(done), 1);
        chk(busy == 1'b0, "R7 busy low at done", longint'(busy), 0);
        y = y_out;
        chk(y < n, "R4 result below n", longint'(y), longint'(n));
        @(negedge clk);
        chk(done == 1'b0, "R7 done one cycle", longint'(done), 0);
        chk(y_out == y, "R7 y held", longint'(y_out), longint'(y));
    endtask

    task automatic t_reset();
        chk(busy == 1'b0, "R9 busy reset", longint'(busy), 0);
        chk(done == 1'b0, "R9 done reset", longint'(done), 0);
        chk(y_out == '0, "R9 y reset", longint'(y_out), 0);
    endtask

    task automatic t_example();
        logic [W-1:0] y; int c;
        run(16'd115, 16'd7, 16'd143, 1'b0, y, c);
        chk(y == 16'd80, "R8 normal", longint'(y), 80);
        run(16'd115, 16'd7, 16'd143, 1'b1, y, c);
        chk(y == 16'd80, "R8 ct", longint'(y), 80);
    endtask

    task automatic t_patterns();
        logic [W-1:0] xs [6] = '{16'd2, 16'd3, 16'd65534, 16'd12345, 16'd0, 16'd7};
        logic [W-1:0] es [6] = '{16'd10, 16'd65535, 16'd2, 16'd40961, 16'd5, 16'd1};
        logic [W-1:0] ns [6] = '{16'd1000, 16'd65521, 16'd65535, 16'd54321, 16'd17, 16'd2};
        for (int i = 0; i < 6; i++) begin
            logic [W-1:0] y; int c;
            longint exp_v = ref_pow(xs[i], es[i], ns[i]);
            run(xs[i], es[i], ns[i], 1'b0, y, c);
            chk(longint'(y) == exp_v, "R1 normal", longint'(y), exp_v);
            run(xs[i], es[i], ns[i], 1'b1, y, c);
            chk(longint'(y) == exp_v, "R5 ct result", longint'(y), exp_v);
        end
    endtask

    task automatic t_zero_exp();
        logic [W-1:0] y; int c;
        run(16'd9, 16'd0, 16'd31, 1'b0, y, c);
        chk(y == 16'd1, "R2 normal e=0", longint'(y), 1);
        run(16'd9, 16'd0, 16'd31, 1'b1, y, c);
        chk(y == 16'd1, "R2 ct e=0", longint'(y), 1);
    endtask

    task automatic t_ct_timing();
        logic [W-1:0] y; int c0, c1, c2;
        run(16'd5, 16'd0, 16'd60013, 1'b1, y, c0);
        run(16'd5, 16'd1, 16'd60013, 1'b1, y, c1);
        run(16'd5, 16'd65535, 16'd60013, 1'b1, y, c2);
        chk(c0 == c1, "R5 ct cycles e=0 vs e=1", c0, c1);
        chk(c2 == c1, "R5 ct cycles e=ffff vs e=1", c2, c1);
    endtask

    task automatic t_skip();
        logic [W-1:0] y; int c_lo, c_hi, c_ct;
        run(16'd5, 16'd1, 16'd60013, 1'b0, y, c_lo);
        run(16'd5, 16'h8000, 16'd60013, 1'b0, y, c_hi);
        run(16'd5, 16'h8000, 16'd60013, 1'b1, y, c_ct);
        chk(c_lo < c_hi, "R6 leading zeros skipped", c_lo, c_hi);
        chk(c_hi < c_ct, "R6 multiply only on set bits", c_hi, c_ct);
    endtask

    task automatic t_busy_ignore();
        logic [W-1:0] y; int c;
        longint exp_v = ref_pow(11, 300, 997);
        @(negedge clk);
        x_in = 16'd11; e_in = 16'd300; n_in = 16'd997; ct_mode = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        x_in = 16'd4; e_in = 16'd3; n_in = 16'd13; ct_mode = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        c = 0;
        while (!done && c < 5000) begin
            @(negedge clk);
            c++;
        end
        y = y_out;
        chk(longint'(y) == exp_v, "R3 start while busy ignored", longint'(y), exp_v);
        @(negedge clk);
        chk(busy == 1'b0, "R3 no second job", longint'(busy), 0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_patterns();
        t_zero_exp();
        t_ct_timing();
        t_skip();
        t_busy_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule